// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block drives the external memory bus of a small 8-bit microcontroller core. It runs on the oscillator clock and divides it into machine cycles of twelve clocks. Each cycle has two six-clock halves. At the end of every machine cycle it samples the core's program counter, the external-access pin and any pending data request. From these it decides what the next cycle does. A cycle is either a code-fetch cycle, with one fetch slot per half, or an external data cycle.

A fetch slot goes to the external bus when the external-access pin is low, or when its address lies beyond the internal program memory. Otherwise the slot stays internal and the program strobe remains idle. During an external slot the block pulses the address latch strobe and drives the low address byte on the multiplexed port. It then lowers the program strobe and captures the returned code byte. A data cycle keeps only its first address-latch pulse and issues no program strobe. In its place it issues one long read or write strobe. A data access uses either a full 16-bit pointer address or an 8-bit address. An 8-bit access puts the port-2 register on the high address lines.

A reset input is filtered. It takes effect only after it has been held high for two full machine cycles.

Top module: `xbus_seq`

## Requirements
- R1: Outside reset, a fetch cycle raises `ale` during clocks 0–1 and 6–7 of the machine cycle, which gives two pulses per twelve clocks. `mc_last` is high in clock 11, and the next cycle's inputs are sampled on the clock edge that ends it.
- R2: A data cycle (`dreq_valid` high when sampled) raises `ale` only in clocks 0–1, omitting the second pulse, and keeps `psen_n` high for the whole cycle.
- R3: An external fetch slot lowers `psen_n` in its clocks 3–5. The first half fetches the sampled `pc` and the second half fetches `pc`+1, wrapping at FFFFh.
- R4: An internal fetch slot leaves `psen_n` high and `p0_oe` low, and shows the port-2 register on `p2_out`.
- R5: With `ea_pin` low when sampled, every slot is external, including address 0000h. With it high, a slot is external exactly when its address is at least `IMEM_BYTES` (default 4096).
- R6: `p2_out` carries address bits 15:8 during external fetch slots and 16-bit data cycles (`dreq_wide`=1). For 8-bit data cycles it carries the port-2 register value held when the request was sampled. At all other times it carries the port-2 register.
- R7: `p0_oe` is high with the low address byte on `p0_out` during clocks 0–2 of every external slot and data cycle, so the address stays valid one clock after `ale` falls. A write drives `dreq_wdata` on clocks 3–10. At all other times the port floats.
- R8: A data read lowers `rd_n`, and a data write (`dreq_write`=1) lowers `wr_n`, during clocks 3–9. The two strobes are never low together, and never low together with `psen_n`.
- R9: `p0_in` is captured into `code_byte` on the last low clock of an external `psen_n`, with `code_valid` high for the following clock. A read captures `p0_in` into `rdata` in clock 9, with `rdata_valid` high in clock 10.
- R10: `reset_pin` high on 24 consecutive edges raises an internal reset, which holds while the pin stays high. A shorter pulse has no effect on the bus.
- R11: In reset, `ale` is low, `psen_n`, `rd_n` and `wr_n` are high, `p0_oe` and both valid flags are low, and `p2_out` is FFh. A write on `p2_we` updates the port-2 register on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low chip reset, released synchronously |
| reset_pin | input | 1 | Filtered active-high reset input |
| ea_pin | input | 1 | External-access select (low forces all fetches external) |
| pc | input | 16 | Program counter of the core |
| dreq_valid | input | 1 | External data request pending |
| dreq_write | input | 1 | 1 = write, 0 = read |
| dreq_wide | input | 1 | 1 = 16-bit pointer access, 0 = 8-bit access |
| dreq_addr | input | 16 | Data address (bits 7:0 only for 8-bit access) |
| dreq_wdata | input | 8 | Write data |
| p2_we | input | 1 | Port-2 register write enable |
| p2_wdata | input | 8 | Port-2 register write value |
| p0_in | input | 8 | Value read from the multiplexed low port |
| mc_last | output | 1 | Last clock of a machine cycle |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Multiplexed low address / write data |
| p0_oe | output | 1 | Drive enable for the low port |
| p2_out | output | 8 | High address port value |
| code_valid | output | 1 | `code_byte` updated |
| code_byte | output | 8 | Last fetched external code byte |
| rdata_valid | output | 1 | `rdata` updated |
| rdata | output | 8 | Last external read byte |

## Verification
The bound checker watches several relations on every clock. It checks that the strobes are mutually exclusive and that `ale` pulses are two clocks wide. It checks that the low address is held through the falling edge of `ale` and that write data is held as `wr_n` rises. It checks that the valid flags follow the rise of the matching strobe, and that the bus is quiet after reset. Other behaviours depend on sampled context and can only be shown by the bench's scenarios against its reference model. These are the choice between internal and external slots around the memory-size boundary, the `pc`+1 wrap and the port-2 value during 8-bit accesses. They also include the omitted pulses of data cycles and the difference between short and long reset pulses.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    MC_IDLE  = 2'd0,
    MC_FETCH = 2'd1,
    MC_DATA  = 2'd2
  } mc_kind_e;

  typedef struct packed {
    mc_kind_e            kind;
    logic                ea;
    logic                wr;
    logic [ADDR_W-1:0]   addr;
    logic [DATA_W-1:0]   wdata;
  } mc_ctx_t;
endpackage

// File: rtl/xbus_rst.sv
// Reset release synchroniser plus a qualification filter on the reset input.
module xbus_rst #(
  parameter int RST_CLKS = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reset_pin,
  output logic arst_n,
  output logic pin_rst
);
  localparam int CW = $clog2(RST_CLKS + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign arst_n = sync_q[1];

  always_comb begin
    cnt_d = cnt_q;
    if (!reset_pin)                cnt_d = '0;
    else if (cnt_q != CW'(RST_CLKS)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign pin_rst = (cnt_q == CW'(RST_CLKS));
endmodule

// File: rtl/xbus_timer.sv
// Machine-cycle phase counter and per-cycle context capture.
module xbus_timer import xbus_pkg::*; #(
  parameter  int MC_CLKS = 12,
  localparam int PH_W    = $clog2(MC_CLKS)
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              pin_rst,
  input  logic              ea_pin,
  input  logic [ADDR_W-1:0] pc,
  input  logic              dreq_valid,
  input  logic              dreq_write,
  input  logic              dreq_wide,
  input  logic [ADDR_W-1:0] dreq_addr,
  input  logic [DATA_W-1:0] dreq_wdata,
  input  logic [DATA_W-1:0] p2_cur,
  output logic [PH_W-1:0]   ph,
  output mc_ctx_t           ctx,
  output logic              mc_last
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(MC_CLKS - 1);

  logic [PH_W-1:0] ph_q, ph_d;
  mc_ctx_t         ctx_q, ctx_d;
  logic            at_end;

  assign at_end = (ph_q == PH_LAST);

  always_comb begin
    ph_d  = at_end ? '0 : ph_q + 1'b1;
    ctx_d = ctx_q;
    if (at_end) begin
      ctx_d.ea    = ea_pin;
      ctx_d.wr    = dreq_write;
      ctx_d.wdata = dreq_wdata;
      if (dreq_valid) begin
        ctx_d.kind = MC_DATA;
        ctx_d.addr = dreq_wide ? dreq_addr : {p2_cur, dreq_addr[7:0]};
      end else begin
        ctx_d.kind = MC_FETCH;
        ctx_d.addr = pc;
      end
    end
    if (pin_rst) begin
      ph_d  = PH_LAST;
      ctx_d = '0;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ph_q  <= PH_LAST;
      ctx_q <= '0;
    end else begin
      ph_q  <= ph_d;
      ctx_q <= ctx_d;
    end
  end

  assign ph      = ph_q;
  assign ctx     = ctx_q;
  assign mc_last = at_end && !pin_rst;
endmodule

// File: rtl/xbus_decode.sv
// Strobe, port and capture decode from phase and cycle context.
module xbus_decode import xbus_pkg::*; #(
  parameter  int STATE_CLKS = 2,
  parameter  int IMEM_BYTES = 4096,
  localparam int MC_CLKS    = 6 * STATE_CLKS,
  localparam int PH_W       = $clog2(MC_CLKS)
) (
  input  logic [PH_W-1:0]   ph,
  input  mc_ctx_t           ctx,
  input  logic [DATA_W-1:0] p2_q,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              p0_oe,
  output logic [DATA_W-1:0] p0_out,
  output logic [DATA_W-1:0] p2_out,
  output logic              cap_code,
  output logic              cap_data
);
  localparam int HALF      = MC_CLKS / 2;
  localparam int ADDR_CLKS = STATE_CLKS + 1;
  localparam int STRB_LAST = MC_CLKS - 3;
  localparam int HOLD_LAST = MC_CLKS - 2;

  logic              second;
  logic [PH_W-1:0]   h;
  logic [ADDR_W-1:0] fa;
  logic              ext;

  always_comb begin
    second   = (ph >= PH_W'(HALF));
    h        = second ? ph - PH_W'(HALF) : ph;
    fa       = ctx.addr + ADDR_W'(second);
    ext      = !ctx.ea || ({1'b0, fa} >= (ADDR_W+1)'(IMEM_BYTES));
    ale      = 1'b0;
    psen_n   = 1'b1;
    rd_n     = 1'b1;
    wr_n     = 1'b1;
    p0_oe    = 1'b0;
    p0_out   = fa[DATA_W-1:0];
    p2_out   = p2_q;
    cap_code = 1'b0;
    cap_data = 1'b0;
    unique case (ctx.kind)
      MC_FETCH: begin
        ale = (h < PH_W'(STATE_CLKS));
        if (ext) begin
          p2_out   = fa[ADDR_W-1:DATA_W];
          p0_oe    = (h < PH_W'(ADDR_CLKS));
          psen_n   = (h < PH_W'(ADDR_CLKS));
          cap_code = (h == PH_W'(HALF - 1));
        end
      end
      MC_DATA: begin
        ale    = (ph < PH_W'(STATE_CLKS));
        p2_out = ctx.addr[ADDR_W-1:DATA_W];
        if (ph < PH_W'(ADDR_CLKS)) begin
          p0_oe  = 1'b1;
          p0_out = ctx.addr[DATA_W-1:0];
        end else if (ctx.wr) begin
          p0_oe  = (ph <= PH_W'(HOLD_LAST));
          p0_out = ctx.wdata;
          wr_n   = (ph > PH_W'(STRB_LAST));
        end else begin
          rd_n     = (ph > PH_W'(STRB_LAST));
          cap_data = (ph == PH_W'(STRB_LAST));
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq import xbus_pkg::*; #(
  parameter int STATE_CLKS = 2,
  parameter int IMEM_BYTES = 4096,
  parameter int RST_MCS    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_pin,
  input  logic              ea_pin,
  input  logic [ADDR_W-1:0] pc,
  input  logic              dreq_valid,
  input  logic              dreq_write,
  input  logic              dreq_wide,
  input  logic [ADDR_W-1:0] dreq_addr,
  input  logic [DATA_W-1:0] dreq_wdata,
  input  logic              p2_we,
  input  logic [DATA_W-1:0] p2_wdata,
  input  logic [DATA_W-1:0] p0_in,
  output logic              mc_last,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] p0_out,
  output logic              p0_oe,
  output logic [DATA_W-1:0] p2_out,
  output logic              code_valid,
  output logic [DATA_W-1:0] code_byte,
  output logic              rdata_valid,
  output logic [DATA_W-1:0] rdata
);
  localparam int MC_CLKS  = 6 * STATE_CLKS;
  localparam int PH_W     = $clog2(MC_CLKS);
  localparam int RST_CLKS = RST_MCS * MC_CLKS;

  logic              arst_n, pin_rst;
  logic [PH_W-1:0]   ph;
  mc_ctx_t           ctx;
  logic              cap_code, cap_data;
  logic [DATA_W-1:0] p2_q, p2_d, code_q, code_d, rdat_q, rdat_d;
  logic              cv_q, cv_d, rv_q, rv_d;

  xbus_rst #(.RST_CLKS(RST_CLKS)) u_rst (
    .clk(clk), .rst_n(rst_n), .reset_pin(reset_pin),
    .arst_n(arst_n), .pin_rst(pin_rst)
  );

  xbus_timer #(.MC_CLKS(MC_CLKS)) u_tmr (
    .clk(clk), .arst_n(arst_n), .pin_rst(pin_rst), .ea_pin(ea_pin), .pc(pc),
    .dreq_valid(dreq_valid), .dreq_write(dreq_write), .dreq_wide(dreq_wide),
    .dreq_addr(dreq_addr), .dreq_wdata(dreq_wdata), .p2_cur(p2_q),
    .ph(ph), .ctx(ctx), .mc_last(mc_last)
  );

  xbus_decode #(.STATE_CLKS(STATE_CLKS), .IMEM_BYTES(IMEM_BYTES)) u_dec (
    .ph(ph), .ctx(ctx), .p2_q(p2_q),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .p0_oe(p0_oe), .p0_out(p0_out), .p2_out(p2_out),
    .cap_code(cap_code), .cap_data(cap_data)
  );

  always_comb begin
    p2_d   = p2_we ? p2_wdata : p2_q;
    cv_d   = cap_code;
    code_d = cap_code ? p0_in : code_q;
    rv_d   = cap_data;
    rdat_d = cap_data ? p0_in : rdat_q;
    if (pin_rst) begin
      p2_d   = '1;
      cv_d   = 1'b0;
      code_d = '0;
      rv_d   = 1'b0;
      rdat_d = '0;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      p2_q   <= '1;
      cv_q   <= 1'b0;
      code_q <= '0;
      rv_q   <= 1'b0;
      rdat_q <= '0;
    end else begin
      p2_q   <= p2_d;
      cv_q   <= cv_d;
      code_q <= code_d;
      rv_q   <= rv_d;
      rdat_q <= rdat_d;
    end
  end

  assign code_valid  = cv_q;
  assign code_byte   = code_q;
  assign rdata_valid = rv_q;
  assign rdata       = rdat_q;
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk (
  input logic       clk,
  input logic       arst_n,
  input logic       pin_rst,
  input logic       ale,
  input logic       psen_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       p0_oe,
  input logic [7:0] p0_out,
  input logic       code_valid,
  input logic       rdata_valid
);
  logic in_rst;
  assign in_rst = !arst_n || pin_rst;

  // R8: read and write strobes never overlap
  a_r8_strobe_exclusive: assert property (@(posedge clk) disable iff (in_rst)
    !(!rd_n && !wr_n));

  // R2 / R8: no program strobe while a data strobe is active
  a_r2_no_psen_in_data: assert property (@(posedge clk) disable iff (in_rst)
    (!rd_n || !wr_n) |-> psen_n);

  // R1: every address latch pulse lasts exactly two clocks
  a_r1_ale_two_clocks: assert property (@(posedge clk) disable iff (in_rst)
    $rose(ale) |=> ale ##1 !ale);

  // R7: low address held on the port through the falling edge of ale
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (in_rst)
    ($fell(ale) && $past(p0_oe) && !$past(pin_rst)) |-> (p0_oe && $stable(p0_out)));

  // R7: write data still driven when the write strobe rises
  a_r7_write_hold: assert property (@(posedge clk) disable iff (in_rst)
    ($rose(wr_n) && !$past(pin_rst)) |-> p0_oe);

  // R9: code byte reported as the program strobe ends
  a_r9_code_valid: assert property (@(posedge clk) disable iff (in_rst)
    ($rose(psen_n) && !$past(pin_rst)) |-> code_valid);

  // R9: read byte reported as the read strobe ends
  a_r9_rdata_valid: assert property (@(posedge clk) disable iff (in_rst)
    ($rose(rd_n) && !$past(pin_rst)) |-> rdata_valid);

  // R11: bus quiet in the clock after any reset
  a_r11_quiet_after_reset: assert property (@(posedge clk)
    in_rst |=> (!ale && psen_n && rd_n && wr_n && !p0_oe && !code_valid && !rdata_valid));
endmodule

bind xbus_seq xbus_seq_chk u_chk (
  .clk(clk), .arst_n(arst_n), .pin_rst(pin_rst), .ale(ale), .psen_n(psen_n),
  .rd_n(rd_n), .wr_n(wr_n), .p0_oe(p0_oe), .p0_out(p0_out),
  .code_valid(code_valid), .rdata_valid(rdata_valid)
);

// File: tb/xbus_seq_bench.sv
`timescale 1ns/1ps
module xbus_seq_bench;
  localparam int IMEM = 4096;
  localparam int RSTC = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0, reset_pin = 1'b0, ea_pin = 1'b1;
  logic dreq_valid = 1'b0, dreq_write = 1'b0, dreq_wide = 1'b0, p2_we = 1'b0;
  logic [15:0] pc = 16'h0000, dreq_addr = 16'h0000;
  logic [7:0]  dreq_wdata = 8'h00, p2_wdata = 8'h00, p0_in = 8'h11;
  logic mc_last, ale, psen_n, rd_n, wr_n, p0_oe, code_valid, rdata_valid;
  logic [7:0] p0_out, p2_out, code_byte, rdata;

  int checks = 0, errors = 0;
  int n_ale, n_psen, n_rd, n_wr, n_cv, n_rv;
  logic pv_ale = 1'b0, pv_psen = 1'b1, pv_rd = 1'b1, pv_wr = 1'b1;
  int s_p2;

  always #2 clk = ~clk;

  xbus_seq u_xbus_seq (
    .clk(clk), .rst_n(rst_n), .reset_pin(reset_pin), .ea_pin(ea_pin), .pc(pc),
    .dreq_valid(dreq_valid), .dreq_write(dreq_write), .dreq_wide(dreq_wide),
    .dreq_addr(dreq_addr), .dreq_wdata(dreq_wdata), .p2_we(p2_we), .p2_wdata(p2_wdata),
    .p0_in(p0_in), .mc_last(mc_last), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out),
    .code_valid(code_valid), .code_byte(code_byte), .rdata_valid(rdata_valid), .rdata(rdata)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_sync, m_cnt, m_ph, m_kind, m_ea, m_wr, m_addr, m_wd, m_p2, m_code, m_cv, m_rdat, m_rv;

  task automatic m_clear();
    m_ph = 11; m_kind = 0; m_ea = 0; m_wr = 0; m_addr = 0; m_wd = 0;
    m_p2 = 255; m_code = 0; m_cv = 0; m_rdat = 0; m_rv = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0; m_cnt = 0; m_clear();
    end else if (m_sync < 2) begin
      m_sync = m_sync + 1;
    end else begin
      int pr, sec, h, fa, ext, op2;
      pr = (m_cnt == RSTC);
      m_cnt = reset_pin ? ((m_cnt < RSTC) ? m_cnt + 1 : m_cnt) : 0;
      if (pr != 0) m_clear();
      else begin
        sec = (m_ph >= 6) ? 1 : 0;
        h   = m_ph - 6 * sec;
        fa  = (m_addr + sec) % 65536;
        ext = (m_ea == 0 || fa >= IMEM) ? 1 : 0;
        m_cv = (m_kind == 1 && ext == 1 && h == 5) ? 1 : 0;
        if (m_cv == 1) m_code = int'(p0_in);
        m_rv = (m_kind == 2 && m_wr == 0 && m_ph == 9) ? 1 : 0;
        if (m_rv == 1) m_rdat = int'(p0_in);
        op2 = m_p2;
        if (p2_we) m_p2 = int'(p2_wdata);
        if (m_ph == 11) begin
          m_ph = 0; m_ea = int'(ea_pin); m_wr = int'(dreq_write); m_wd = int'(dreq_wdata);
          if (dreq_valid) begin
            m_kind = 2;
            m_addr = dreq_wide ? int'(dreq_addr) : op2 * 256 + int'(dreq_addr[7:0]);
          end else begin
            m_kind = 1; m_addr = int'(pc);
          end
        end else m_ph = m_ph + 1;
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    int sec, h, fa, ext, e_ale, e_psen, e_rd, e_wr, e_oe, e_p0, e_p2, e_ml;
    sec = (m_ph >= 6) ? 1 : 0;
    h   = m_ph - 6 * sec;
    fa  = (m_addr + sec) % 65536;
    ext = (m_ea == 0 || fa >= IMEM) ? 1 : 0;
    e_ale = 0; e_psen = 1; e_rd = 1; e_wr = 1; e_oe = 0; e_p0 = 0; e_p2 = m_p2;
    e_ml = (m_ph == 11 && m_cnt != RSTC) ? 1 : 0;
    if (m_kind == 1) begin
      e_ale = (h < 2) ? 1 : 0;
      if (ext == 1) begin
        e_p2 = fa / 256; e_oe = (h < 3) ? 1 : 0; e_p0 = fa % 256;
        e_psen = (h >= 3) ? 0 : 1;
      end
    end else if (m_kind == 2) begin
      e_ale = (m_ph < 2) ? 1 : 0; e_p2 = m_addr / 256;
      if (m_ph < 3) begin e_oe = 1; e_p0 = m_addr % 256; end
      else if (m_wr == 1) begin
        e_oe = (m_ph <= 10) ? 1 : 0; e_p0 = m_wd; e_wr = (m_ph <= 9) ? 0 : 1;
      end else e_rd = (m_ph <= 9) ? 0 : 1;
    end
    chk("R1 mc_last", int'(mc_last), e_ml);
    chk("R1 ale", int'(ale), e_ale);
    chk("R3 psen_n", int'(psen_n), e_psen);
    chk("R8 rd_n", int'(rd_n), e_rd);
    chk("R8 wr_n", int'(wr_n), e_wr);
    chk("R7 p0_oe", int'(p0_oe), e_oe);
    if (e_oe == 1) chk("R7 p0_out", int'(p0_out), e_p0);
    chk("R6 p2_out", int'(p2_out), e_p2);
    chk("R9 code_valid", int'(code_valid), m_cv);
    chk("R9 code_byte", int'(code_byte), m_code);
    chk("R9 rdata_valid", int'(rdata_valid), m_rv);
    chk("R9 rdata", int'(rdata), m_rdat);
    if (ale && !pv_ale) n_ale++;
    if (!psen_n && pv_psen) n_psen++;
    if (!rd_n && pv_rd) n_rd++;
    if (!wr_n && pv_wr) n_wr++;
    if (code_valid) n_cv++;
    if (rdata_valid) n_rv++;
    pv_ale = ale; pv_psen = psen_n; pv_rd = rd_n; pv_wr = wr_n;
    p0_in <= p0_in * 8'd5 + 8'd37;
  end

  task automatic wait_last();
    do @(negedge clk); while (mc_last !== 1'b1);
  endtask

  // one machine cycle with given request; counts strobes over it
  task automatic run_mc(logic v, logic w, logic wide, logic [15:0] a, logic [7:0] d);
    wait_last();
    dreq_valid = v; dreq_write = w; dreq_wide = wide; dreq_addr = a; dreq_wdata = d;
    n_ale = 0; n_psen = 0; n_rd = 0; n_wr = 0; n_cv = 0; n_rv = 0;
    @(negedge clk);
    dreq_valid = 1'b0;
    repeat (4) @(negedge clk);
    s_p2 = int'(p2_out);
    repeat (7) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset p2_out", int'(p2_out), 8'hFF);
    chk("R11 reset psen_n", int'(psen_n), 1);
    chk("R11 reset ale", int'(ale), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    ea_pin = 1'b1; pc = 16'h0100;
    run_mc(0, 0, 0, 0, 0);
    chk("R1 two ale pulses per fetch cycle", n_ale, 2);
    chk("R4 no psen for internal fetch", n_psen, 0);
    chk("R4 p2 shows register on internal fetch", s_p2, 8'hFF);

    pc = 16'h0FFF;
    run_mc(0, 0, 0, 0, 0);
    chk("R5 boundary: only second slot external", n_psen, 1);

    ea_pin = 1'b0; pc = 16'h0000;
    run_mc(0, 0, 0, 0, 0);
    chk("R5 ea low forces external at 0000", n_psen, 2);
    chk("R9 two code bytes captured", n_cv, 2);

    pc = 16'hFFFF;
    run_mc(0, 0, 0, 0, 0);
    chk("R3 wrap fetch strobes", n_psen, 2);

    run_mc(1, 0, 1, 16'h1234, 8'h00);
    chk("R2 one ale in data cycle", n_ale, 1);
    chk("R2 no psen in data cycle", n_psen, 0);
    chk("R8 one read strobe", n_rd, 1);
    chk("R9 one read capture", n_rv, 1);
    chk("R6 wide high address", s_p2, 8'h12);

    run_mc(1, 1, 1, 16'hBEEF, 8'hC3);
    chk("R8 one write strobe", n_wr, 1);
    chk("R8 no read on write", n_rd, 0);

    wait_last();
    p2_we = 1'b1; p2_wdata = 8'h5A;
    @(negedge clk); p2_we = 1'b0;
    run_mc(1, 0, 0, 16'hFF77, 8'h00);
    chk("R11 p2 write / R6 narrow high byte", s_p2, 8'h5A);

    ea_pin = 1'b1; pc = 16'h2000;
    reset_pin = 1'b1; repeat (10) @(negedge clk); reset_pin = 1'b0;
    run_mc(0, 0, 0, 0, 0);
    chk("R10 short reset pulse ignored", n_psen, 2);
    chk("R10 p2 kept after short pulse", int'(u_xbus_seq.p2_out), 8'h20);

    reset_pin = 1'b1; repeat (30) @(negedge clk);
    chk("R10 long reset: ale low", int'(ale), 0);
    chk("R10 long reset: psen_n high", int'(psen_n), 1);
    chk("R11 long reset: p2_out FF", int'(p2_out), 8'hFF);
    chk("R10 long reset: no mc_last", int'(mc_last), 0);
    reset_pin = 1'b0;
    run_mc(0, 0, 0, 0, 0);
    chk("R1 fetch resumes after reset", n_ale, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule